// File: doc/BRIEF.md
# Multichannel Event Scaler with Snapshot Register

The block holds a bank of independent event counters, one per input channel. Each channel receives a one-cycle count strobe that is synchronous to the system clock, and its counter adds one for every strobe. A second register set, the snapshot, copies every counter in the same clock edge. The host can then read a consistent image of the whole bank while the counters keep running. A snapshot is taken on a host command, on an external capture strobe, or as a side effect of two of the read modes.

Counters clear on the OR of several sources: an external clear, a clear for one channel, a clear for a group, a clear-all command, and the implicit clear of a read-and-clear access. Each channel has a sticky wrap flag, and the flags can be read one group at a time. An optional exact mode stops all counting for a fixed number of cycles from each capture onwards, which trades dead time for a snapshot that matches the counters exactly. Narrow hosts can fetch a counter in two accesses, upper half first.

Top module: `scaler_bank`

## Requirements
- R1: Each cycle in which `cnt_strobe[i]` is high and no inhibit or clear applies, counter i increases by one modulo 2^CNT_W.
- R2: A pulse on `cmd_capture` or `ext_capture`, or a read in mode 1 or 2, copies every counter into the snapshot in one edge. The copied value is the one held before that cycle's increments, and counting goes on.
- R3: `rd_mode`=0 returns the snapshot of channel `rd_ch` and never takes a new snapshot.
- R4: `rd_mode`=1 returns the counter value at the access, takes a snapshot, and leaves the counters unchanged.
- R5: `rd_mode`=2 returns the counter value at the access, takes a snapshot, and clears every counter in that cycle. Wrap flags are not changed.
- R6: A counter clears when any of these is high: `ext_clear`, `cmd_clear_all`, a read in mode 2, or `cmd_clear_ch` with `cmd_ch` equal to its index. A clear wins over an increment in the same cycle.
- R7: `cmd_clear_grp` clears the counters and wrap flags of channels `cmd_grp`*GROUP to `cmd_grp`*GROUP+GROUP-1. `cmd_clear_ovf` clears only the wrap flag of channel `cmd_ch`. `cmd_clear_all` and `cmd_clear_ch` also clear the wrap flags they address.
- R8: A wrap flag sets when its counter steps from all ones to zero and stays set until it is cleared. `ovf_any` is high while any flag is set.
- R9: `rd_mode`=3 returns in bit j the wrap flag of channel g*GROUP+j, where g = `rd_ch`/GROUP. All higher bits are zero.
- R10: With `exact_mode` high, every capture stops counting on all channels for INHIBIT_CYC cycles, starting with the capture cycle. A capture inside the window restarts it.
- R11: When `rd_narrow` is high in modes 0 to 2, accesses alternate. The first returns bits CNT_W-1..CNT_W/2 and has the side effects of its mode. The second returns bits CNT_W/2-1..0 of the snapshot and has no side effect. A wide read in modes 0 to 2, or reset, makes the next narrow access a first one. Mode 3 does not move the alternation.
- R12: After reset all counters, snapshots and flags are zero, and `rd_valid` and `ovf_any` are low.
- R13: `rd_valid` is high exactly one cycle after a cycle with `rd_en` high, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_strobe | input | NUM_CH | One-cycle count strobe per channel |
| ext_capture | input | 1 | External snapshot strobe |
| ext_clear | input | 1 | External clear of all counters |
| exact_mode | input | 1 | Stop counting for a window after each capture |
| cmd_capture | input | 1 | Host snapshot command |
| cmd_clear_all | input | 1 | Clear all counters and flags |
| cmd_clear_ch | input | 1 | Clear counter and flag of channel `cmd_ch` |
| cmd_clear_grp | input | 1 | Clear counters and flags of group `cmd_grp` |
| cmd_clear_ovf | input | 1 | Clear only the flag of channel `cmd_ch` |
| cmd_ch | input | CH_W | Channel index for channel commands |
| cmd_grp | input | GRP_W | Group index for group clear |
| rd_en | input | 1 | Read strobe |
| rd_mode | input | 2 | 0 snapshot, 1 live with capture, 2 live with capture and clear, 3 group flags |
| rd_narrow | input | 1 | Half-width read, upper half first |
| rd_ch | input | CH_W | Channel (or group member) to read |
| rd_data | output | CNT_W | Read result, registered |
| rd_valid | output | 1 | Read result valid |
| ovf_any | output | 1 | OR of all wrap flags |

## Verification
The bench builds the block with 8 channels, 10-bit counters, groups of 4 and a 4-cycle inhibit window. With 10-bit counters, a single channel driven continuously wraps within about a thousand cycles, so flag setting, stickiness and the group read of both groups come within reach. The odd half width of 5 bits tests the narrow split on a width that is not a byte multiple. The short window lets random captures fall inside a running inhibit window, so restarts are exercised along with plain counting.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

  typedef enum logic [1:0] {
    RD_SHADOW = 2'd0,
    RD_LIVE   = 2'd1,
    RD_CLEAR  = 2'd2,
    RD_OVF    = 2'd3
  } rd_mode_e;

  // Read modes that take a snapshot as a side effect.
  function automatic logic takes_snapshot(input rd_mode_e m);
    return (m == RD_LIVE) || (m == RD_CLEAR);
  endfunction

  // Read modes that split into two accesses when the host is narrow.
  function automatic logic splits_narrow(input rd_mode_e m);
    return m != RD_OVF;
  endfunction

endpackage

// File: rtl/scaler_chan.sv
module scaler_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             inhibit,
  input  logic             clr_cnt,
  input  logic             clr_ovf,
  input  logic             capture,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] shadow,
  output logic             ovf,
  output logic             wrap
);

  // Sum with carry out; carry marks the step from all ones to zero.
  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] v, input logic en);
    return {1'b0, v} + {{CNT_W{1'b0}}, en};
  endfunction

  logic             live_inc;
  logic [CNT_W:0]   sum;

  assign live_inc = inc && !inhibit;
  assign sum      = step(cnt, live_inc);
  assign wrap     = sum[CNT_W] && !clr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      shadow <= '0;
      ovf    <= 1'b0;
    end else begin
      if (clr_cnt)      cnt <= '0;
      else              cnt <= sum[CNT_W-1:0];
      if (capture)      shadow <= cnt;
      if (clr_ovf)      ovf <= 1'b0;
      else if (wrap)    ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int GROUP       = 8,
  parameter int INHIBIT_CYC = 10,
  parameter int CH_W        = 5,
  parameter int GRP_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_capture,
  input  logic              ext_clear,
  input  logic              exact_mode,
  input  logic              cmd_capture,
  input  logic              cmd_clear_all,
  input  logic              cmd_clear_ch,
  input  logic              cmd_clear_grp,
  input  logic              cmd_clear_ovf,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic [GRP_W-1:0]  cmd_grp,
  input  logic              rd_en,
  input  rd_mode_e          eff_mode,
  output logic              capture,
  output logic              inhibit,
  output logic [NUM_CH-1:0] clr_cnt,
  output logic [NUM_CH-1:0] clr_ovf
);

  localparam int INH_W = $clog2(INHIBIT_CYC + 1);

  logic             read_clear;
  logic             start_inh;
  logic [INH_W-1:0] inh_left;

  assign read_clear = rd_en && (eff_mode == RD_CLEAR);
  assign capture    = cmd_capture || ext_capture || (rd_en && takes_snapshot(eff_mode));
  assign start_inh  = capture && exact_mode;
  assign inhibit    = start_inh || (inh_left != '0);

  // Remaining inhibit cycles after the current one.
  always_ff @(posedge clk) begin
    if (!rst_n)                inh_left <= '0;
    else if (start_inh)        inh_left <= INH_W'(INHIBIT_CYC - 1);
    else if (inh_left != '0)   inh_left <= inh_left - 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    logic ch_hit, grp_hit;
    assign ch_hit  = (cmd_ch == CH_W'(i));
    assign grp_hit = cmd_clear_grp && (cmd_grp == GRP_W'(i / GROUP));
    assign clr_cnt[i] = ext_clear || cmd_clear_all || read_clear
                        || (cmd_clear_ch && ch_hit) || grp_hit;
    assign clr_ovf[i] = cmd_clear_all || grp_hit
                        || ((cmd_clear_ch || cmd_clear_ovf) && ch_hit);
  end

endmodule

// File: rtl/scaler_rdport.sv
module scaler_rdport
  import scaler_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32,
  parameter int GROUP  = 8,
  parameter int CH_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  rd_mode_e                     rd_mode,
  input  logic                         rd_narrow,
  input  logic [CH_W-1:0]              rd_ch,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input  logic [NUM_CH-1:0][CNT_W-1:0] shadow_all,
  input  logic [NUM_CH-1:0]            ovf_flags,
  output rd_mode_e                     eff_mode,
  output logic                         half_q,
  output logic [CNT_W-1:0]             rd_data,
  output logic                         rd_valid
);

  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((64'd1 << HALF) - 64'd1);

  function automatic logic [CNT_W-1:0] narrow_part(input logic [CNT_W-1:0] v,
                                                   input logic lower);
    return lower ? (v & LOW_MASK) : (v >> HALF);
  endfunction

  function automatic logic [CNT_W-1:0] group_flags(input logic [NUM_CH-1:0] f,
                                                   input logic [CH_W-1:0] ch);
    logic [CNT_W-1:0] r;
    int base;
    r    = '0;
    base = (int'(ch) / GROUP) * GROUP;
    for (int j = 0; j < GROUP; j++) r[j] = f[base + j];
    return r;
  endfunction

  logic             split;
  logic [CNT_W-1:0] src;
  logic [CNT_W-1:0] next_data;

  assign split    = rd_narrow && splits_narrow(rd_mode);
  assign eff_mode = (split && half_q) ? RD_SHADOW : rd_mode;

  always_comb begin
    src = (eff_mode == RD_SHADOW) ? shadow_all[rd_ch] : cnt_all[rd_ch];
    if (rd_mode == RD_OVF) next_data = group_flags(ovf_flags, rd_ch);
    else if (split)        next_data = narrow_part(src, half_q);
    else                   next_data = src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      half_q   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_data;
      if (rd_en && splits_narrow(rd_mode)) half_q <= rd_narrow ? !half_q : 1'b0;
    end
  end

endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
  import scaler_pkg::*;
#(
  parameter int NUM_CH      = 32,
  parameter int CNT_W       = 32,
  parameter int GROUP       = 8,
  parameter int INHIBIT_CYC = 10,
  localparam int NUM_GRP    = NUM_CH / GROUP,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int GRP_W      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cnt_strobe,
  input  logic              ext_capture,
  input  logic              ext_clear,
  input  logic              exact_mode,
  input  logic              cmd_capture,
  input  logic              cmd_clear_all,
  input  logic              cmd_clear_ch,
  input  logic              cmd_clear_grp,
  input  logic              cmd_clear_ovf,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic [GRP_W-1:0]  cmd_grp,
  input  logic              rd_en,
  input  logic [1:0]        rd_mode,
  input  logic              rd_narrow,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              ovf_any
);

  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0][CNT_W-1:0] shadow_all;
  logic [NUM_CH-1:0]            ovf_flags;
  logic [NUM_CH-1:0]            wrap_vec;
  logic [NUM_CH-1:0]            clr_cnt_vec;
  logic [NUM_CH-1:0]            clr_ovf_vec;
  logic                         capture;
  logic                         inhibit;
  logic                         half_q;
  rd_mode_e                     eff_mode;

  scaler_ctrl #(
    .NUM_CH(NUM_CH), .GROUP(GROUP), .INHIBIT_CYC(INHIBIT_CYC),
    .CH_W(CH_W), .GRP_W(GRP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext_capture(ext_capture), .ext_clear(ext_clear), .exact_mode(exact_mode),
    .cmd_capture(cmd_capture), .cmd_clear_all(cmd_clear_all),
    .cmd_clear_ch(cmd_clear_ch), .cmd_clear_grp(cmd_clear_grp),
    .cmd_clear_ovf(cmd_clear_ovf), .cmd_ch(cmd_ch), .cmd_grp(cmd_grp),
    .rd_en(rd_en), .eff_mode(eff_mode),
    .capture(capture), .inhibit(inhibit),
    .clr_cnt(clr_cnt_vec), .clr_ovf(clr_ovf_vec)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    scaler_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .inc(cnt_strobe[i]), .inhibit(inhibit),
      .clr_cnt(clr_cnt_vec[i]), .clr_ovf(clr_ovf_vec[i]), .capture(capture),
      .cnt(cnt_all[i]), .shadow(shadow_all[i]),
      .ovf(ovf_flags[i]), .wrap(wrap_vec[i])
    );
  end

  scaler_rdport #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .GROUP(GROUP), .CH_W(CH_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_mode(rd_mode_e'(rd_mode)), .rd_narrow(rd_narrow),
    .rd_ch(rd_ch), .cnt_all(cnt_all), .shadow_all(shadow_all),
    .ovf_flags(ovf_flags), .eff_mode(eff_mode), .half_q(half_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign ovf_any = |ovf_flags;

endmodule

// File: rtl/scaler_bank_chk.sv
module scaler_bank_chk #(
  parameter int NUM_CH = 32,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_en,
  input logic                         rd_valid,
  input logic                         ovf_any,
  input logic                         cmd_clear_all,
  input logic                         capture,
  input logic                         inhibit,
  input logic [NUM_CH-1:0]            wrap_vec,
  input logic [NUM_CH-1:0]            clr_cnt_vec,
  input logic [NUM_CH-1:0]            clr_ovf_vec,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] shadow_all
);

  // R13
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R13
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ovf_any);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_any && !(|clr_ovf_vec)) |=> ovf_any);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear_all |=> (cnt_all == '0));

  // R10
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !(|clr_cnt_vec)) |=> $stable(cnt_all));

  // R2
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (shadow_all == $past(cnt_all)));

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(shadow_all));

endmodule

bind scaler_bank scaler_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .ovf_any(ovf_any), .cmd_clear_all(cmd_clear_all), .capture(capture),
  .inhibit(inhibit), .wrap_vec(wrap_vec), .clr_cnt_vec(clr_cnt_vec),
  .clr_ovf_vec(clr_ovf_vec), .cnt_all(cnt_all), .shadow_all(shadow_all)
);

// File: tb/sim_scaler_bank.sv
module sim_scaler_bank;
  localparam int NCH  = 8;
  localparam int W    = 10;
  localparam int GRP  = 4;
  localparam int INH  = 4;
  localparam int CHW  = 3;
  localparam int GW   = 1;
  localparam int HALF = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] cnt_strobe = '0;
  logic ext_capture = 0, ext_clear = 0, exact_mode = 0, cmd_capture = 0;
  logic cmd_clear_all = 0, cmd_clear_ch = 0, cmd_clear_grp = 0, cmd_clear_ovf = 0;
  logic [CHW-1:0] cmd_ch = '0;
  logic [GW-1:0]  cmd_grp = '0;
  logic rd_en = 0, rd_narrow = 0;
  logic [1:0] rd_mode = '0;
  logic [CHW-1:0] rd_ch = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, ovf_any;

  scaler_bank #(.NUM_CH(NCH), .CNT_W(W), .GROUP(GRP), .INHIBIT_CYC(INH)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_strobe(cnt_strobe), .ext_capture(ext_capture),
    .ext_clear(ext_clear), .exact_mode(exact_mode), .cmd_capture(cmd_capture),
    .cmd_clear_all(cmd_clear_all), .cmd_clear_ch(cmd_clear_ch),
    .cmd_clear_grp(cmd_clear_grp), .cmd_clear_ovf(cmd_clear_ovf),
    .cmd_ch(cmd_ch), .cmd_grp(cmd_grp), .rd_en(rd_en), .rd_mode(rd_mode),
    .rd_narrow(rd_narrow), .rd_ch(rd_ch), .rd_data(rd_data),
    .rd_valid(rd_valid), .ovf_any(ovf_any)
  );

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  logic [W-1:0] m_cnt [NCH];
  logic [W-1:0] m_shd [NCH];
  logic         m_ovf [NCH];
  logic         m_hp = 1'b0;
  int           m_inh = 0;
  string        cur_tag = "";

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    cnt_strobe = '0; ext_capture = 0; ext_clear = 0; cmd_capture = 0;
    cmd_clear_all = 0; cmd_clear_ch = 0; cmd_clear_grp = 0; cmd_clear_ovf = 0;
    rd_en = 0; rd_narrow = 0;
  endtask

  function automatic logic any_ovf();
    logic r = 1'b0;
    for (int i = 0; i < NCH; i++) r |= m_ovf[i];
    return r;
  endfunction

  // Requirement tag for a read, from its mode and width.
  function automatic string read_tag(input logic [1:0] m, input logic nar);
    if (nar && m != 2'd3) return "R11";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R9";
    endcase
  endfunction

  // Advance the reference by one clock edge, check outputs after it.
  task automatic tick();
    int em;
    logic cap, inh, clr, oclr, inc, wr, was_rd;
    logic [W-1:0] src, expv;
    string tag;
    em = rd_mode;
    if (rd_en && rd_narrow && m_hp && rd_mode != 2'd3) em = 0;
    cap = cmd_capture || ext_capture || (rd_en && (em == 1 || em == 2));
    inh = (cap && exact_mode) || (m_inh > 0);
    expv = '0;
    was_rd = rd_en;
    tag = (cur_tag != "") ? cur_tag : read_tag(rd_mode, rd_narrow);
    if (rd_en) begin
      if (rd_mode == 2'd3) begin
        for (int j = 0; j < GRP; j++) expv[j] = m_ovf[(int'(rd_ch) / GRP) * GRP + j];
      end else begin
        src = (em == 0) ? m_shd[rd_ch] : m_cnt[rd_ch];
        if (rd_narrow) expv = m_hp ? (src & W'((1 << HALF) - 1)) : (src >> HALF);
        else           expv = src;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      clr  = ext_clear || cmd_clear_all || (rd_en && em == 2)
             || (cmd_clear_ch && int'(cmd_ch) == i)
             || (cmd_clear_grp && int'(cmd_grp) == i / GRP);
      oclr = cmd_clear_all || (cmd_clear_grp && int'(cmd_grp) == i / GRP)
             || ((cmd_clear_ch || cmd_clear_ovf) && int'(cmd_ch) == i);
      inc  = cnt_strobe[i] && !inh;
      wr   = !clr && inc && (m_cnt[i] == '1);
      if (cap) m_shd[i] = m_cnt[i];
      if (clr)      m_cnt[i] = '0;
      else if (inc) m_cnt[i] = m_cnt[i] + 1'b1;
      if (oclr)     m_ovf[i] = 1'b0;
      else if (wr)  m_ovf[i] = 1'b1;
    end
    if (cap && exact_mode) m_inh = INH - 1;
    else if (m_inh > 0)    m_inh = m_inh - 1;
    if (rd_en && rd_mode != 2'd3) m_hp = rd_narrow ? !m_hp : 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R13", W'(rd_valid), W'(was_rd));
    if (was_rd) check(tag, rd_data, expv);
    check("R8", W'(ovf_any), W'(any_ovf()));
    idle();
  endtask

  task automatic rd(input logic [1:0] m, input int ch, input logic nar);
    rd_en = 1; rd_mode = m; rd_ch = CHW'(ch); rd_narrow = nar;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin m_cnt[i] = '0; m_shd[i] = '0; m_ovf[i] = 1'b0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", W'(rd_valid), '0);
    check("R12", W'(ovf_any), '0);
    cur_tag = "R12"; rd(2'd1, 3, 0); cur_tag = "";

    // R1 counting on distinct patterns, read back live
    for (int k = 0; k < 5; k++) begin cnt_strobe = 8'b1010_0110; tick(); end
    for (int k = 0; k < 3; k++) begin cnt_strobe = 8'b0000_0011; tick(); end
    cur_tag = "R1";
    for (int c = 0; c < NCH; c++) rd(2'd1, c, 0);
    cur_tag = "";

    // R2 command and external capture, counting continues
    cmd_capture = 1; cnt_strobe = '1; tick();
    for (int k = 0; k < 4; k++) begin cnt_strobe = '1; tick(); end
    cur_tag = "R2"; rd(2'd0, 1, 0); rd(2'd0, 2, 0); cur_tag = "";
    ext_capture = 1; tick();
    cur_tag = "R2"; rd(2'd0, 1, 0); cur_tag = "";
    // R3 shadow read repeated leaves snapshot alone
    for (int k = 0; k < 3; k++) begin cnt_strobe = '1; tick(); end
    rd(2'd0, 1, 0); rd(2'd0, 1, 0);
    // R4 then R5
    rd(2'd1, 5, 0); rd(2'd0, 5, 0);
    rd(2'd2, 6, 0); rd(2'd1, 6, 0); rd(2'd0, 6, 0);

    // R6 clear beats increment, per-channel and external clears
    for (int k = 0; k < 6; k++) begin cnt_strobe = '1; tick(); end
    cmd_clear_ch = 1; cmd_ch = 3; cnt_strobe = '1; tick();
    cur_tag = "R6"; rd(2'd1, 3, 0); rd(2'd1, 4, 0);
    ext_clear = 1; cnt_strobe = '1; tick();
    rd(2'd1, 0, 0); cur_tag = "";

    // R8 wrap on channel 0 and channel 5
    for (int k = 0; k < (1 << W) + 3; k++) begin cnt_strobe = 8'b0010_0001; tick(); end
    rd(2'd3, 0, 0); rd(2'd3, 5, 0);
    // R7 flag-only clear, then group clear
    cmd_clear_ovf = 1; cmd_ch = 0; tick();
    cur_tag = "R7"; rd(2'd3, 0, 0); rd(2'd1, 0, 0);
    cmd_clear_grp = 1; cmd_grp = 1; tick();
    rd(2'd3, 4, 0); rd(2'd1, 5, 0); cur_tag = "";

    // R10 exact capture window and restart
    exact_mode = 1;
    for (int k = 0; k < 3; k++) begin cnt_strobe = '1; tick(); end
    cmd_capture = 1; cnt_strobe = '1; tick();
    for (int k = 0; k < 2; k++) begin cnt_strobe = '1; tick(); end
    cmd_capture = 1; cnt_strobe = '1; tick();
    for (int k = 0; k < 6; k++) begin cnt_strobe = '1; tick(); end
    cur_tag = "R10"; rd(2'd0, 2, 0); rd(2'd1, 2, 0); cur_tag = "";
    exact_mode = 0;
    for (int k = 0; k < 6; k++) begin cnt_strobe = '1; tick(); end

    // R11 narrow pairs, mode 3 in between, wide read resets alternation
    rd(2'd2, 7, 1); rd(2'd3, 7, 0); rd(2'd0, 7, 1);
    rd(2'd1, 2, 1); rd(2'd1, 2, 0); rd(2'd0, 2, 1); rd(2'd0, 2, 1);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      cnt_strobe = NCH'($urandom);
      if (($urandom % 200) == 0) exact_mode = !exact_mode;
      cmd_capture   = ($urandom % 40) == 0;
      ext_capture   = ($urandom % 60) == 0;
      ext_clear     = ($urandom % 400) == 0;
      cmd_clear_all = ($urandom % 900) == 0;
      cmd_clear_ch  = ($urandom % 80) == 0;
      cmd_clear_grp = ($urandom % 300) == 0;
      cmd_clear_ovf = ($urandom % 100) == 0;
      cmd_ch  = CHW'($urandom);
      cmd_grp = GW'($urandom);
      rd_en   = ($urandom % 4) == 0;
      rd_mode = 2'($urandom);
      if (rd_mode == 2'd2 && ($urandom % 4) != 0) rd_mode = 2'd1;
      rd_narrow = ($urandom % 3) == 0;
      rd_ch = CHW'($urandom);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule